// File: doc/BRIEF.md
# Auto-Increment Word-Program Sequencer

This block sits beside the command decoder of a serial flash engine and runs a multi-frame word-program mode. A starting frame carries the word-program opcode, a three-byte address and two data bytes; once accepted, it turns on a sticky mode bit and writes the two bytes into the array. From then on, each short frame with the same opcode carries just two data bytes. These are written at an internal pointer that moves forward by two after every word and wraps at the array size. While the mode is on, only three opcodes are allowed: word-program, write-disable and status-read. Every other opcode is refused. Write-disable ends the mode. When the feature is switched off at build time, the word-program opcode is reported as unknown.

The decoder presents each frame as one pulse. The pulse carries the opcode, the frame's byte count and the bytes that follow the opcode. The block answers one cycle later with a response code. Array writes leave one byte per cycle through a byte-write port. The state machine has four states, and the mode bit is on in every state except ST_IDLE:
- ST_IDLE: the mode is off.
- ST_ARMED: the mode is on and the block waits for the next frame.
- ST_PUT_LO: the first byte of a word is written.
- ST_PUT_HI: the second byte is written.

The transitions are:
- T_START (ST_IDLE to ST_PUT_LO): a valid starting frame.
- T_NEXT (ST_ARMED to ST_PUT_LO): a valid continuation frame.
- T_EXIT (ST_ARMED to ST_IDLE): write-disable.
- T_HALF (ST_PUT_LO to ST_PUT_HI): always taken.
- T_DONE (ST_PUT_HI to ST_ARMED): always taken. The pointer steps by two on this transition.

Top module: `wprog_word_seq`

## Requirements
- R1: After reset the block is in ST_IDLE. In that state `mode_active`, `wr_en` and `resp_valid` are 0 and `frm_ready` is 1.
- R2: A frame in ST_IDLE with opcode OP_WORD (default 0xAD) and length 6 gives response DONE (code 1) and sets `mode_active`. Its tail holds address byte 2 in bits 7:0, address byte 1 in bits 15:8, address byte 0 in bits 23:16, data byte A in bits 31:24 and data byte B in bits 39:32. Let the address be {bits 7:0, 15:8, 23:16} modulo ARRAY_BYTES. The block then writes byte A at that address in the first write cycle and byte B at the address plus 1 (wrapped) in the next cycle.
- R3: An OP_WORD frame in ST_IDLE whose length is not 6 gives response BADLEN (code 2). It writes nothing and leaves `mode_active` at 0.
- R4: An OP_WORD frame of length 3 while the mode is on gives DONE. It writes tail bits 7:0 at the pointer and then bits 15:8 at the pointer plus 1. The pointer is the previous word's address plus 2, modulo ARRAY_BYTES.
- R5: An OP_WORD frame of any length other than 3 while the mode is on gives BADLEN. It writes nothing, keeps the mode on and leaves the pointer unchanged.
- R6: While the mode is on, any opcode other than OP_WORD, OP_WDIS (default 0x04) and OP_RDST (default 0x05) gives FORBID (code 3). It writes nothing and leaves the mode and pointer as they were.
- R7: OP_RDST while the mode is on gives PASS (code 0) and keeps the mode on.
- R8: OP_WDIS while the mode is on gives PASS and clears `mode_active`.
- R9: In ST_IDLE, any opcode other than OP_WORD gives PASS, writes nothing and leaves the mode off.
- R10: With SEQ_EN = 0, OP_WORD of any length gives UNKNOWN (code 4). `mode_active` never rises in that configuration.
- R11: `resp_valid` is high for exactly the one cycle after a frame is taken. `frm_ready` is low during both write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_valid | input | 1 | One-cycle frame strobe from the decoder |
| frm_ready | output | 1 | Block can take a frame this cycle |
| frm_op | input | 8 | Frame opcode |
| frm_len | input | LEN_W | Total byte count of the frame, opcode included |
| frm_tail | input | 40 | Bytes after the opcode; byte k in bits 8k-1:8k-8 |
| wr_en | output | 1 | Array byte-write strobe |
| wr_addr | output | log2(ARRAY_BYTES) | Array byte address |
| wr_data | output | 8 | Array byte data |
| mode_active | output | 1 | Sticky sequence mode bit for the status register |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 3 | 0 PASS, 1 DONE, 2 BADLEN, 3 FORBID, 4 UNKNOWN |

## Verification
The assertions assume that the decoder raises `frm_valid` only while `frm_ready` is high. They also assume that a frame strobe lasts exactly one cycle. The stimulus keeps within both: every frame is driven for one cycle starting at a falling edge, and a frame is only started after the previous write pair has finished. The sweeps cover every start address of a 64-byte array, with junk in the address bits above the array range. They also cover every opcode in both the idle and armed states, and every frame length for both frame kinds.

// File: rtl/wprog_pkg.sv
package wprog_pkg;

    // response codes returned one cycle after a frame is taken
    typedef enum logic [2:0] {
        RSP_PASS    = 3'd0,
        RSP_DONE    = 3'd1,
        RSP_BADLEN  = 3'd2,
        RSP_FORBID  = 3'd3,
        RSP_UNKNOWN = 3'd4
    } resp_e;

    // frame classification produced by the classifier
    typedef enum logic [2:0] {
        CL_PASS,
        CL_START,
        CL_NEXT,
        CL_BADLEN,
        CL_FORBID,
        CL_UNKNOWN,
        CL_EXIT
    } class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PUT_LO,
        ST_PUT_HI
    } state_e;

    localparam int unsigned START_FRAME_BYTES = 6;
    localparam int unsigned NEXT_FRAME_BYTES  = 3;
    localparam int unsigned TAIL_BYTES        = 5;

endpackage

// File: rtl/wprog_classify.sv
module wprog_classify
    import wprog_pkg::*;
#(
    parameter bit          SEQ_EN  = 1'b1,
    parameter int unsigned LEN_W   = 4,
    parameter logic [7:0]  OP_WORD = 8'hAD,
    parameter logic [7:0]  OP_WDIS = 8'h04,
    parameter logic [7:0]  OP_RDST = 8'h05
) (
    input  logic [7:0]       op,
    input  logic [LEN_W-1:0] len,
    input  logic             mode_on,
    output class_e           cls
);
    localparam logic [LEN_W-1:0] START_LEN = LEN_W'(START_FRAME_BYTES);
    localparam logic [LEN_W-1:0] NEXT_LEN  = LEN_W'(NEXT_FRAME_BYTES);

    logic is_word;
    logic is_wdis;
    logic is_rdst;

    assign is_word = (op == OP_WORD);
    assign is_wdis = (op == OP_WDIS);
    assign is_rdst = (op == OP_RDST);

    always_comb begin
        cls = CL_PASS;
        if (is_word) begin
            if (!SEQ_EN) begin
                cls = CL_UNKNOWN;
            end else if (!mode_on) begin
                cls = (len == START_LEN) ? CL_START : CL_BADLEN;
            end else begin
                cls = (len == NEXT_LEN) ? CL_NEXT : CL_BADLEN;
            end
        end else if (mode_on) begin
            // whitelist applies only while the sequence is running
            if (is_wdis) begin
                cls = CL_EXIT;
            end else if (is_rdst) begin
                cls = CL_PASS;
            end else begin
                cls = CL_FORBID;
            end
        end
    end

endmodule

// File: rtl/wprog_addr.sv
module wprog_addr #(
    parameter int unsigned AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] cur_plus1
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] ptr_q;

    // width of AW bits gives the modulo-array-size wrap for free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (step) begin
            ptr_q <= ptr_q + TWO;
        end
    end

    assign cur       = ptr_q;
    assign cur_plus1 = ptr_q + ONE;

endmodule

// File: rtl/wprog_word_seq.sv
module wprog_word_seq
    import wprog_pkg::*;
#(
    parameter int unsigned ARRAY_BYTES = 4194304,
    parameter bit          SEQ_EN      = 1'b1,
    parameter int unsigned LEN_W       = 4,
    parameter logic [7:0]  OP_WORD     = 8'hAD,
    parameter logic [7:0]  OP_WDIS     = 8'h04,
    parameter logic [7:0]  OP_RDST     = 8'h05
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frm_valid,
    output logic                           frm_ready,
    input  logic [7:0]                     frm_op,
    input  logic [LEN_W-1:0]               frm_len,
    input  logic [39:0]                    frm_tail,
    output logic                           wr_en,
    output logic [$clog2(ARRAY_BYTES)-1:0] wr_addr,
    output logic [7:0]                     wr_data,
    output logic                           mode_active,
    output logic                           resp_valid,
    output logic [2:0]                     resp_code
);
    localparam int unsigned AW = $clog2(ARRAY_BYTES);

    state_e        state_q;
    state_e        state_d;
    class_e        cls;
    logic          take;
    logic          mode_on;
    logic [23:0]   frm_addr;
    logic [AW-1:0] ptr_cur;
    logic [AW-1:0] ptr_plus1;
    logic [7:0]    byte_lo_q;
    logic [7:0]    byte_hi_q;
    resp_e         resp_d;

    assign mode_on  = (state_q != ST_IDLE);
    assign take     = frm_valid && frm_ready;
    // big-endian address in the first three tail bytes
    assign frm_addr = {frm_tail[7:0], frm_tail[15:8], frm_tail[23:16]};

    wprog_classify #(
        .SEQ_EN (SEQ_EN),
        .LEN_W  (LEN_W),
        .OP_WORD(OP_WORD),
        .OP_WDIS(OP_WDIS),
        .OP_RDST(OP_RDST)
    ) u_cls (
        .op     (frm_op),
        .len    (frm_len),
        .mode_on(mode_on),
        .cls    (cls)
    );

    wprog_addr #(
        .AW(AW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take && (cls == CL_START)),
        .load_addr(frm_addr[AW-1:0]),
        .step     (state_q == ST_PUT_HI),
        .cur      (ptr_cur),
        .cur_plus1(ptr_plus1)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions T_START, T_NEXT, T_EXIT, T_HALF, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && (cls == CL_START)) state_d = ST_PUT_LO;
            end
            ST_ARMED: begin
                if (take && (cls == CL_NEXT)) begin
                    state_d = ST_PUT_LO;
                end else if (take && (cls == CL_EXIT)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PUT_LO: state_d = ST_PUT_HI;
            ST_PUT_HI: state_d = ST_ARMED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // word data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_lo_q <= '0;
            byte_hi_q <= '0;
        end else if (take && (cls == CL_START)) begin
            byte_lo_q <= frm_tail[31:24];
            byte_hi_q <= frm_tail[39:32];
        end else if (take && (cls == CL_NEXT)) begin
            byte_lo_q <= frm_tail[7:0];
            byte_hi_q <= frm_tail[15:8];
        end
    end

    // response mapping
    always_comb begin
        unique case (cls)
            CL_START, CL_NEXT: resp_d = RSP_DONE;
            CL_BADLEN:         resp_d = RSP_BADLEN;
            CL_FORBID:         resp_d = RSP_FORBID;
            CL_UNKNOWN:        resp_d = RSP_UNKNOWN;
            default:           resp_d = RSP_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_PASS;
        end else begin
            resp_valid <= take;
            if (take) resp_code <= resp_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        frm_ready   = 1'b0;
        wr_en       = 1'b0;
        wr_addr     = ptr_cur;
        wr_data     = byte_lo_q;
        mode_active = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                frm_ready   = 1'b1;
                mode_active = 1'b0;
            end
            ST_ARMED: begin
                frm_ready = 1'b1;
            end
            ST_PUT_LO: begin
                wr_en   = 1'b1;
                wr_addr = ptr_cur;
                wr_data = byte_lo_q;
            end
            ST_PUT_HI: begin
                wr_en   = 1'b1;
                wr_addr = ptr_plus1;
                wr_data = byte_hi_q;
            end
            default: begin
                mode_active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wprog_word_seq_chk.sv
module wprog_word_seq_chk #(
    parameter int unsigned AW      = 22,
    parameter int unsigned LEN_W   = 4,
    parameter logic [7:0]  OP_WORD = 8'hAD,
    parameter logic [7:0]  OP_WDIS = 8'h04
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             frm_ready,
    input logic [7:0]       frm_op,
    input logic [LEN_W-1:0] frm_len,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic             mode_active,
    input logic             resp_valid
);
    // R2
    mode_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> $past(frm_valid && frm_op == OP_WORD && frm_len == LEN_W'(6)));

    // R2
    byte_pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |=> (wr_en && wr_addr == AW'($past(wr_addr) + 1'b1)));

    // R4
    pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |=> !wr_en);

    // R6
    write_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mode_active);

    // R8
    mode_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_active) |-> $past(frm_valid && frm_op == OP_WDIS));

    // R11
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready) |=> resp_valid);

    // R11
    busy_while_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !frm_ready);

endmodule

bind wprog_word_seq wprog_word_seq_chk #(
    .AW     (AW),
    .LEN_W  (LEN_W),
    .OP_WORD(OP_WORD),
    .OP_WDIS(OP_WDIS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .frm_op     (frm_op),
    .frm_len    (frm_len),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .mode_active(mode_active),
    .resp_valid (resp_valid)
);

// File: tb/wprog_word_seq_tb.sv
module wprog_word_seq_tb;
    localparam int unsigned SZ = 64;
    localparam int unsigned AW = 6;
    localparam logic [7:0] OPW = 8'hAD;
    localparam logic [7:0] OPD = 8'h04;
    localparam logic [7:0] OPR = 8'h05;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v_on = 1'b0;
    logic v_off = 1'b0;
    logic [7:0] f_op = '0;
    logic [3:0] f_len = '0;
    logic [39:0] f_tail = '0;

    logic rdy, wen, mact, rv;
    logic [AW-1:0] wa;
    logic [7:0] wd;
    logic [2:0] rc;
    logic rdy_x, wen_x, mact_x, rv_x;
    logic [AW-1:0] wa_x;
    logic [7:0] wd_x;
    logic [2:0] rc_x;

    int checks = 0;
    int failures = 0;
    int m_ptr = 0;

    always #2 clk = ~clk;

    wprog_word_seq #(.ARRAY_BYTES(SZ), .SEQ_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(v_on), .frm_ready(rdy),
        .frm_op(f_op), .frm_len(f_len), .frm_tail(f_tail),
        .wr_en(wen), .wr_addr(wa), .wr_data(wd), .mode_active(mact),
        .resp_valid(rv), .resp_code(rc));

    wprog_word_seq #(.ARRAY_BYTES(SZ), .SEQ_EN(1'b0)) u_dut_dis (
        .clk(clk), .rst_n(rst_n), .frm_valid(v_off), .frm_ready(rdy_x),
        .frm_op(f_op), .frm_len(f_len), .frm_tail(f_tail),
        .wr_en(wen_x), .wr_addr(wa_x), .wr_data(wd_x), .mode_active(mact_x),
        .resp_valid(rv_x), .resp_code(rc_x));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one frame for one cycle; returns at the falling edge after capture
    task automatic send(input bit to_dis, input logic [7:0] op, input int len,
                        input logic [39:0] tail);
        @(negedge clk);
        f_op = op;
        f_len = 4'(len);
        f_tail = tail;
        v_on = !to_dis;
        v_off = to_dis;
        @(negedge clk);
        v_on = 1'b0;
        v_off = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int code, input bit mode);
        chk(req, "resp_valid", int'(rv), 1);
        chk(req, "resp_code", int'(rc), code);
        chk(req, "wr_en", int'(wen), 0);
        chk(req, "mode", int'(mact), int'(mode));
        chk(req, "ready", int'(rdy), 1);
    endtask

    task automatic expect_pair(input string req, input int a, input int d0, input int d1);
        chk(req, "resp_code", int'(rc), 1);
        chk("R11", "resp_valid lo", int'(rv), 1);
        chk("R11", "ready lo", int'(rdy), 0);
        chk(req, "wen lo", int'(wen), 1);
        chk(req, "addr lo", int'(wa), a % SZ);
        chk(req, "data lo", int'(wd), d0);
        @(negedge clk);
        chk("R11", "resp_valid hi", int'(rv), 0);
        chk("R11", "ready hi", int'(rdy), 0);
        chk(req, "wen hi", int'(wen), 1);
        chk(req, "addr hi", int'(wa), (a + 1) % SZ);
        chk(req, "data hi", int'(wd), d1);
        @(negedge clk);
        chk(req, "wen after", int'(wen), 0);
        chk(req, "ready after", int'(rdy), 1);
        chk(req, "mode after", int'(mact), 1);
    endtask

    task automatic word_next(input string req, input int d0, input int d1);
        send(1'b0, OPW, 3, {24'h0, 8'(d1), 8'(d0)});
        expect_pair(req, m_ptr, d0, d1);
        m_ptr = (m_ptr + 2) % SZ;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode", int'(mact), 0);
        chk("R1", "wr_en", int'(wen), 0);
        chk("R1", "resp_valid", int'(rv), 0);
        chk("R1", "ready", int'(rdy), 1);

        // R9 idle sweep over all non-word opcodes
        for (int op = 0; op < 256; op++) begin
            if (8'(op) == OPW) continue;
            send(1'b0, 8'(op), op % 16, 40'(op * 40'h0101_0101));
            expect_quiet("R9", 0, 1'b0);
        end

        // R3 starting frame with wrong lengths
        for (int len = 0; len < 16; len++) begin
            if (len == 6) continue;
            send(1'b0, OPW, len, 40'hFF_EE_00_00_01);
            expect_quiet("R3", 2, 1'b0);
        end

        // R2 R4 R5 R6 R7 R8 over every start address
        for (int a = 0; a < int'(SZ); a++) begin
            int hi;
            int full;
            hi = (a * 7 + 1) & 16'h3FFF;
            full = (hi << 6) | a;
            send(1'b0, OPW, 6, {8'(~a), 8'(a), 8'(full), 8'(full >> 8), 8'(full >> 16)});
            expect_pair("R2", a, a & 255, (~a) & 255);
            m_ptr = (a + 2) % SZ;
            for (int k = 1; k <= 3; k++) begin
                word_next("R4", (a + k) & 255, (k * 17) & 255);
            end
            send(1'b0, OPW, 2, 40'h0);
            expect_quiet("R5", 2, 1'b1);
            if (a == 5) begin
                for (int len = 0; len < 16; len++) begin
                    if (len == 3) continue;
                    send(1'b0, OPW, len, 40'h0);
                    expect_quiet("R5", 2, 1'b1);
                end
                for (int op = 0; op < 256; op++) begin
                    if (8'(op) == OPW || 8'(op) == OPD || 8'(op) == OPR) continue;
                    send(1'b0, 8'(op), 1, 40'h0);
                    expect_quiet("R6", 3, 1'b1);
                end
            end
            // pointer unchanged by refused frames (R5, R6)
            word_next("R5", 8'h5A, a & 255);
            send(1'b0, OPR, 1, 40'h0);
            expect_quiet("R7", 0, 1'b1);
            send(1'b0, OPD, 1, 40'h0);
            expect_quiet("R8", 0, 1'b0);
        end

        // R10 disabled instance
        for (int len = 0; len < 16; len++) begin
            send(1'b1, OPW, len, 40'h11_22_00_00_00);
            chk("R10", "resp_valid", int'(rv_x), 1);
            chk("R10", "resp_code", int'(rc_x), 4);
            chk("R10", "wr_en", int'(wen_x), 0);
            chk("R10", "mode", int'(mact_x), 0);
            @(negedge clk);
            chk("R10", "mode later", int'(mact_x), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule